// File: doc/BRIEF.md
# Register Window Trap Entry Unit

This block performs the processor-state update that happens when a trap is taken on a machine with rotating register windows. An external trap source presents a pulse on `trap_valid` together with an 8-bit trap type. In the same cycle the surrounding core presents its current program counter, next program counter, window pointer, supervisor bit, trap-enable bit and trap base register. On the next clock edge the block publishes the updated values. The window pointer moves down by one and wraps modulo the window count. Traps become disabled. The old supervisor bit is kept as the previous-supervisor bit and supervisor mode is forced on. The trap base register receives the trap type in its vector field, and the program counters are redirected to that vector.

The old program counter and the old next program counter must be kept in the new window. The block writes them into the register file one after the other through a single write port. During those two cycles it holds `busy` high. A trap that arrives while traps are already disabled cannot be serviced. In that case the block enters a sticky error state, changes nothing else, and only reset clears that state.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, every output is zero: `upd_valid`, `busy`, `error_state`, `rf_we`, and all published state fields.
- R2: A trap accepted while `cur_et` is 0 sets `error_state` on the next edge. It raises neither `upd_valid` nor `rf_we`, and every published state field keeps its value.
- R3: Once set, `error_state` stays high until reset, and `trap_valid` has no effect while it is high. Only reset clears it.
- R4: On a serviced trap, `new_cwp` equals `cur_cwp` minus 1 modulo `NWIN` (0 becomes `NWIN`-1), and `new_et` is 0.
- R5: In the first cycle after acceptance, `rf_we`=1, `rf_idx`=1 (local register 1), `rf_win`=`new_cwp` and `rf_data`=the old PC.
- R6: In the second cycle after acceptance, `rf_we`=1, `rf_idx`=2 (local register 2), `rf_win`=`new_cwp` and `rf_data`=the old nPC. In the third cycle `rf_we`=0.
- R7: On a serviced trap, `new_ps` equals the old `cur_s`, and `new_s` is 1.
- R8: On a serviced trap, `new_tbr` keeps bits 31:12 of `cur_tbr`, places `trap_type` in bits 11:4, and sets bits 3:0 to zero.
- R9: On a serviced trap, `new_pc` equals the new `new_tbr`, and `new_npc` equals `new_tbr` + 4 (modulo 2^32).
- R10: `upd_valid` is a single-cycle pulse on the edge after an accepted `trap_valid`. `busy` is high in exactly the two write cycles, and a `trap_valid` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | A trap is presented this cycle |
| trap_type | input | 8 | Trap type number |
| cur_pc | input | 32 | Current program counter |
| cur_npc | input | 32 | Current next program counter |
| cur_cwp | input | WPW | Current window pointer |
| cur_s | input | 1 | Current supervisor bit |
| cur_et | input | 1 | Current trap-enable bit |
| cur_tbr | input | 32 | Current trap base register |
| upd_valid | output | 1 | Published state is new this cycle |
| new_pc | output | 32 | Redirected program counter |
| new_npc | output | 32 | Redirected next program counter |
| new_cwp | output | WPW | New window pointer |
| new_s | output | 1 | New supervisor bit |
| new_ps | output | 1 | New previous-supervisor bit |
| new_et | output | 1 | New trap-enable bit |
| new_tbr | output | 32 | Updated trap base register |
| rf_we | output | 1 | Register-file write strobe |
| rf_win | output | WPW | Window of the write |
| rf_idx | output | 3 | Local register index of the write |
| rf_data | output | 32 | Write data |
| busy | output | 1 | Save writes in progress |
| error_state | output | 1 | Sticky error state |

## Verification
The published state fields and `upd_valid` are due one edge after the cycle in which `trap_valid` is high. The local-1 write is due in that same cycle, the local-2 write one cycle later, and `busy` falls one cycle after that. `error_state` rises one edge after a trap that arrives with traps disabled. The bench drives inputs on the falling edge. A behavioural model advances on every rising edge: it pushes the two pending writes into a queue and pops one per cycle. Every output is compared with the model on every falling edge, so each result is checked exactly in the cycle it is due, and any early, late or extra activity also shows up as a mismatch.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int XLEN  = 32;
  localparam int TTW   = 8;
  localparam int IDXW  = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOC1 = 2'd1,
    PH_LOC2 = 2'd2
  } save_phase_t;

  // Vector formation: keep base field, insert trap type at 11:4, clear 3:0
  function automatic logic [XLEN-1:0] form_vector(input logic [XLEN-1:0] tbr,
                                                  input logic [TTW-1:0]  tt);
    return {tbr[XLEN-1:12], tt, 4'h0};
  endfunction

  function automatic logic [XLEN-1:0] step_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction
endpackage

// File: rtl/trap_wnd_dec.sv
module trap_wnd_dec #(
  parameter int NWIN = 8,
  localparam int WPW = $clog2(NWIN)
) (
  input  logic [WPW-1:0] cwp_in,
  output logic [WPW-1:0] cwp_out
);
  function automatic logic [WPW-1:0] wrap_dec(input logic [WPW-1:0] w);
    return (w == '0) ? WPW'(NWIN - 1) : w - WPW'(1);
  endfunction

  assign cwp_out = wrap_dec(cwp_in);

  initial begin
    win_pow2_chk: assert ((NWIN >= 2) && ((NWIN & (NWIN - 1)) == 0))
      else $error("NWIN must be a power of two");
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_valid,
  input  logic        cur_et,
  output logic        service_evt,
  output logic        fault_evt,
  output save_phase_t phase,
  output logic        busy,
  output logic        err
);
  logic take_evt;

  assign busy        = (phase != PH_IDLE);
  assign take_evt    = trap_valid && !busy && !err;
  assign service_evt = take_evt && cur_et;
  assign fault_evt   = take_evt && !cur_et;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      err   <= 1'b0;
    end else begin
      if (fault_evt) err <= 1'b1;
      unique case (phase)
        PH_IDLE: if (service_evt) phase <= PH_LOC1;
        PH_LOC1: phase <= PH_LOC2;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R10
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOC1) |=> (phase == PH_LOC2));
  // R10
  phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
  // R2
  fault_no_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (phase == PH_IDLE));
endmodule

// File: rtl/trap_rf_port.sv
module trap_rf_port
  import trap_entry_pkg::*;
#(
  parameter int WPW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              service_evt,
  input  save_phase_t       phase,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   npc_in,
  input  logic [WPW-1:0]    win_in,
  output logic              rf_we,
  output logic [WPW-1:0]    rf_win,
  output logic [IDXW-1:0]   rf_idx,
  output logic [XLEN-1:0]   rf_data
);
  logic [XLEN-1:0] saved_pc, saved_npc;
  logic [WPW-1:0]  saved_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_pc  <= '0;
      saved_npc <= '0;
      saved_win <= '0;
    end else if (service_evt) begin
      saved_pc  <= pc_in;
      saved_npc <= npc_in;
      saved_win <= win_in;
    end
  end

  assign rf_we   = (phase != PH_IDLE);
  assign rf_win  = saved_win;
  assign rf_idx  = (phase == PH_LOC1) ? IDXW'(1) : (phase == PH_LOC2) ? IDXW'(2) : '0;
  assign rf_data = (phase == PH_LOC2) ? saved_npc : (phase == PH_LOC1) ? saved_pc : '0;

  // R6
  loc2_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_idx == IDXW'(1)) |=> (rf_we && rf_idx == IDXW'(2) && $stable(rf_win)));
  // R6
  write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_idx == IDXW'(2)) |=> !rf_we);
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int WPW = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_valid,
  input  logic [7:0]       trap_type,
  input  logic [31:0]      cur_pc,
  input  logic [31:0]      cur_npc,
  input  logic [WPW-1:0]   cur_cwp,
  input  logic             cur_s,
  input  logic             cur_et,
  input  logic [31:0]      cur_tbr,
  output logic             upd_valid,
  output logic [31:0]      new_pc,
  output logic [31:0]      new_npc,
  output logic [WPW-1:0]   new_cwp,
  output logic             new_s,
  output logic             new_ps,
  output logic             new_et,
  output logic [31:0]      new_tbr,
  output logic             rf_we,
  output logic [WPW-1:0]   rf_win,
  output logic [2:0]       rf_idx,
  output logic [31:0]      rf_data,
  output logic             busy,
  output logic             error_state
);
  logic            service_evt, fault_evt;
  save_phase_t     phase;
  logic [WPW-1:0]  dec_cwp;
  logic [31:0]     vec;

  trap_wnd_dec #(.NWIN(NWIN)) u_dec (.cwp_in(cur_cwp), .cwp_out(dec_cwp));

  trap_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .cur_et(cur_et),
    .service_evt(service_evt), .fault_evt(fault_evt), .phase(phase),
    .busy(busy), .err(error_state)
  );

  trap_rf_port #(.WPW(WPW)) u_rf (
    .clk(clk), .rst_n(rst_n), .service_evt(service_evt), .phase(phase),
    .pc_in(cur_pc), .npc_in(cur_npc), .win_in(dec_cwp),
    .rf_we(rf_we), .rf_win(rf_win), .rf_idx(rf_idx), .rf_data(rf_data)
  );

  assign vec = form_vector(cur_tbr, trap_type);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      new_pc    <= '0;
      new_npc   <= '0;
      new_cwp   <= '0;
      new_s     <= 1'b0;
      new_ps    <= 1'b0;
      new_et    <= 1'b0;
      new_tbr   <= '0;
    end else begin
      upd_valid <= service_evt;
      if (service_evt) begin
        new_tbr <= vec;
        new_pc  <= vec;
        new_npc <= step_pc(vec);
        new_cwp <= dec_cwp;
        new_ps  <= cur_s;
        new_s   <= 1'b1;
        new_et  <= 1'b0;
      end
    end
  end

  // R10
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);
  // R5
  upd_starts_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (rf_we && rf_idx == 3'd1 && rf_win == new_cwp));
  // R9
  npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (new_npc == new_pc + 32'd4 && new_pc == new_tbr));
  // R2
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_state) |-> (!upd_valid && !rf_we && $stable(new_pc)));
endmodule

// File: tb/tb_trap_entry_unit.sv
`timescale 1ns/1ps
module tb_trap_entry_unit;
  localparam int NWIN = 8;
  localparam int WPW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 1'b0;
  logic [7:0] trap_type = '0;
  logic [31:0] cur_pc = '0, cur_npc = '0, cur_tbr = '0;
  logic [WPW-1:0] cur_cwp = '0;
  logic cur_s = 1'b0, cur_et = 1'b0;

  logic upd_valid, new_s, new_ps, new_et, rf_we, busy, error_state;
  logic [31:0] new_pc, new_npc, new_tbr, rf_data;
  logic [WPW-1:0] new_cwp, rf_win;
  logic [2:0] rf_idx;

  trap_entry_unit #(.NWIN(NWIN)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  // behavioural model
  typedef struct { int idx; int win; logic [31:0] data; } wr_t;
  wr_t pend[$];
  bit m_upd, m_busy, m_err, m_we, m_s, m_ps, m_et;
  logic [31:0] m_pc, m_npc, m_tbr, m_data;
  int m_cwp, m_win, m_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend.delete();
      m_upd = 0; m_busy = 0; m_err = 0; m_we = 0; m_s = 0; m_ps = 0; m_et = 0;
      m_pc = 0; m_npc = 0; m_tbr = 0; m_data = 0; m_cwp = 0; m_win = 0; m_idx = 0;
    end else begin
      m_upd = 0;
      if (trap_valid && !m_busy && !m_err) begin
        if (!cur_et) m_err = 1;
        else begin
          int w;
          w = (int'(cur_cwp) + NWIN - 1) % NWIN;
          m_upd = 1;
          m_cwp = w;
          m_tbr = (cur_tbr & 32'hFFFF_F000) | (32'(trap_type) * 16);
          m_pc  = m_tbr;
          m_npc = m_tbr + 4;
          m_ps  = cur_s;
          m_s   = 1;
          m_et  = 0;
          pend.push_back('{1, w, cur_pc});
          pend.push_back('{2, w, cur_npc});
        end
      end
      if (pend.size() > 0) begin
        wr_t e;
        e = pend.pop_front();
        m_we = 1; m_busy = 1; m_idx = e.idx; m_win = e.win; m_data = e.data;
      end else begin
        m_we = 0; m_busy = 0; m_idx = 0;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    check("R10 upd_valid", 32'(upd_valid), 32'(m_upd));
    check("R10 busy", 32'(busy), 32'(m_busy));
    check("R3 error_state", 32'(error_state), 32'(m_err));
    check("R6 rf_we", 32'(rf_we), 32'(m_we));
    if (m_we) begin
      check("R5 rf_idx", 32'(rf_idx), 32'(m_idx));
      check("R5 rf_win", 32'(rf_win), 32'(m_win));
      check("R6 rf_data", rf_data, m_data);
    end
    check("R4 new_cwp", 32'(new_cwp), 32'(m_cwp));
    check("R4 new_et", 32'(new_et), 32'(m_et));
    check("R7 new_s", 32'(new_s), 32'(m_s));
    check("R7 new_ps", 32'(new_ps), 32'(m_ps));
    check("R8 new_tbr", new_tbr, m_tbr);
    check("R9 new_pc", new_pc, m_pc);
    check("R9 new_npc", new_npc, m_npc);
  end

  task automatic trap(input logic [7:0] tt, input logic [31:0] pc,
                      input logic [31:0] npc, input int cwp, input bit s,
                      input bit et, input logic [31:0] tbr, input int hold);
    @(negedge clk);
    trap_type = tt; cur_pc = pc; cur_npc = npc; cur_cwp = WPW'(cwp);
    cur_s = s; cur_et = et; cur_tbr = tbr; trap_valid = 1'b1;
    repeat (hold) @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    started = 1;
    idle(2);                 // R1: reset state compared while rst_n low
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    // R4 R5 R6 R7 R8 R9 varied patterns, including window 0 wrap
    trap(8'h2A, 32'h0000_1000, 32'h0000_1004, 3, 0, 1, 32'h4000_0000, 1); idle(4);
    trap(8'hFF, 32'hDEAD_BEE0, 32'hDEAD_BEE4, 0, 1, 1, 32'hABCD_E123, 1); idle(4);
    trap(8'h00, 32'hFFFF_FFFC, 32'h0000_0000, 7, 1, 1, 32'hFFFF_FFFF, 1); idle(4);
    trap(8'h81, 32'h1234_5678, 32'h8765_4320, 1, 0, 1, 32'h0000_0FF0, 1); idle(1);
    // R10: trap held three cycles, later ones ignored while busy, then retaken
    trap(8'h11, 32'h0000_2000, 32'h0000_2004, 5, 0, 1, 32'h1000_0000, 3); idle(5);
    trap(8'h12, 32'h0000_3000, 32'h0000_3004, 6, 1, 1, 32'h2000_0000, 1);
    trap(8'h13, 32'h0000_4000, 32'h0000_4004, 2, 0, 1, 32'h3000_0000, 1); idle(4);
    // R2: trap with traps disabled
    trap(8'h55, 32'h0000_5000, 32'h0000_5004, 4, 1, 0, 32'h5000_0000, 1); idle(3);
    // R3: further traps ignored while in error
    trap(8'h66, 32'h0000_6000, 32'h0000_6004, 1, 0, 1, 32'h6000_0000, 2); idle(4);
    // R3: only reset clears
    @(negedge clk) rst_n = 1'b0;
    idle(2);
    @(negedge clk) rst_n = 1'b1;
    trap(8'h77, 32'h0000_7000, 32'h0000_7004, 0, 0, 1, 32'h7000_0000, 1); idle(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hang expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule